// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A four-wire test bus (test clock, mode select, serial data in, serial data out) walks a sixteen-state controller. The controller moves an 8-bit instruction register, a 1-bit bypass register and a 32-bit identification register through their capture, shift and update phases. Mode select and data in are sampled on the rising test-clock edge. Serial data out, its drive enable and the current instruction all change on the falling edge.

The loaded instruction is decoded into outputs for the rest of the chip:
- an operation code,
- a data-register select,
- a test-mode flag, which inhibits the normal logic,
- a pins-float flag.

When the boundary or control register is selected, this block gives the external register its capture, shift and update strobes and passes its serial output to data out. The most significant instruction bit is an even-parity bit over the whole byte. A byte with an odd number of ones, or an unknown code, behaves as the bypass instruction.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `rst` is high at a rising `tck` edge, the controller enters Test-Logic-Reset. At the following falling edge the instruction becomes identification read: `op_code`=1, `dr_sel`=1, `test_mode`=0, `pins_hiz`=0, `tdo_oe`=0, `run_active`=0.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. This restores the identification-read instruction at the next falling edge.
- R3: On leaving Capture-IR the instruction shift register holds 8'b1000_0001. In Shift-IR it is shifted out least-significant bit first, while `tdi` enters at bit 7.
- R4: `tdo_oe` rises at the first falling edge after entering Shift-DR or Shift-IR. It falls at the first falling edge after entering Exit1. It never changes at a rising edge.
- R5: A scan of N bits shifts exactly N times. No shift happens on the edge that enters the shift state, and the last shift happens on the edge that leaves it.
- R6: A new instruction takes effect at the falling edge after entering Update-IR. While in Update-IR before that edge, the outputs still show the previous instruction.
- R7: An instruction byte with an odd number of ones decodes as bypass (`op_code`=0, `dr_sel`=0), whatever its lower seven bits.
- R8: Valid codes on bits 6..0 decode as follows (op_code, dr_sel, test_mode, pins_hiz):
  - 7'h7F bypass (0,0,0,0)
  - 7'h01 identification read (1,1,0,0)
  - 7'h02 sample (2,2,0,0)
  - 7'h00 external test (3,2,1,0)
  - 7'h06 float pins (4,0,0,1)
  - 7'h07 clamp (5,0,1,0)
  - 7'h09 run test (6,0,1,0)
  - 7'h03 boundary read (7,2,0,0)
  - 7'h0A boundary self test (8,2,0,0)
  - 7'h0B toggle outputs (9,0,1,0)
  - 7'h0E control-register scan (10,3,0,0)
- R9: An even-parity byte whose bits 6..0 are not listed in R8 decodes as bypass.
- R10: The bypass register captures 0 in Capture-DR and delays `tdi` by one bit in Shift-DR.
- R11: The identification register captures 32'h0002702F and shifts out bit 0 first.
- R12: When `dr_sel` is 2 (boundary) or 3 (control), `tdo` shows `ext_so` during Shift-DR. In that case `dr_capture`, `dr_shift` and `dr_update` are high in Capture-DR, Shift-DR and Update-DR respectively. With any other selection they stay low, and at most one of them is high at a time.
- R13: `run_active` is high exactly while the controller is in Run-Test/Idle and the instruction is run test or toggle outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| ext_so | input | 1 | Serial output of the external boundary/control register |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| op_code | output | 4 | Decoded operation code |
| dr_sel | output | 2 | Data register select: 0 bypass, 1 identification, 2 boundary, 3 control |
| test_mode | output | 1 | Normal logic inhibited |
| pins_hiz | output | 1 | Device pins floated |
| run_active | output | 1 | Run-type instruction executing in Run-Test/Idle |
| dr_capture | output | 1 | External register capture strobe |
| dr_shift | output | 1 | External register shift strobe |
| dr_update | output | 1 | External register update strobe |

## Verification
Each serial output bit is due half a cycle after the rising edge that moved or shifted the register. The bench predicts every bit of a scan before it starts and queues it. A monitor compares one queued bit 2 ns after each falling edge on which `tdo_oe` is high. Decoded instruction outputs are checked twice: 1 ns after the rising edge that enters Update-IR, where the old value must remain, and 2 ns after the next falling edge, where the new value must appear. Drive-enable and strobe checks sit 1 ns after rising edges, so each one sees the level set by the preceding falling edge or the current state.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'b1000_0001;
  localparam logic [IR_W-1:0] IR_RESET   = 8'b1000_0001;

  // lower seven bits of each supported opcode
  localparam logic [6:0] C_EXTEST   = 7'h00;
  localparam logic [6:0] C_IDCODE   = 7'h01;
  localparam logic [6:0] C_SAMPLE   = 7'h02;
  localparam logic [6:0] C_BREAD    = 7'h03;
  localparam logic [6:0] C_HIGHZ    = 7'h06;
  localparam logic [6:0] C_CLAMP    = 7'h07;
  localparam logic [6:0] C_RUNT     = 7'h09;
  localparam logic [6:0] C_SELFTEST = 7'h0A;
  localparam logic [6:0] C_TOGGLE   = 7'h0B;
  localparam logic [6:0] C_BCRSCAN  = 7'h0E;
  localparam logic [6:0] C_BYPASS   = 7'h7F;

  typedef enum logic [3:0] {
    ST_RESET  = 4'h0, ST_IDLE   = 4'h1,
    ST_SEL_DR = 4'h2, ST_CAP_DR = 4'h3, ST_SHF_DR = 4'h4, ST_EX1_DR = 4'h5,
    ST_PAU_DR = 4'h6, ST_EX2_DR = 4'h7, ST_UPD_DR = 4'h8,
    ST_SEL_IR = 4'h9, ST_CAP_IR = 4'hA, ST_SHF_IR = 4'hB, ST_EX1_IR = 4'hC,
    ST_PAU_IR = 4'hD, ST_EX2_IR = 4'hE, ST_UPD_IR = 4'hF
  } tap_state_t;

  typedef enum logic [3:0] {
    OP_BYPASS = 4'd0, OP_IDCODE = 4'd1, OP_SAMPLE = 4'd2, OP_EXTEST = 4'd3,
    OP_HIGHZ = 4'd4, OP_CLAMP = 4'd5, OP_RUNT = 4'd6, OP_BREAD = 4'd7,
    OP_SELFTEST = 4'd8, OP_TOGGLE = 4'd9, OP_BCRSCAN = 4'd10
  } op_t;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0, DR_IDENT = 2'd1, DR_BOUNDARY = 2'd2, DR_CONTROL = 2'd3
  } dr_sel_t;

  typedef struct packed {
    op_t     op;
    dr_sel_t sel;
    logic    test;
    logic    hiz;
  } instr_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic instr_t decode(input logic [IR_W-1:0] code);
    instr_t d;
    d = '{op: OP_BYPASS, sel: DR_BYPASS, test: 1'b0, hiz: 1'b0};
    if ((^code) == 1'b0) begin
      case (code[6:0])
        C_IDCODE:   begin d.op = OP_IDCODE;   d.sel = DR_IDENT;    end
        C_SAMPLE:   begin d.op = OP_SAMPLE;   d.sel = DR_BOUNDARY; end
        C_EXTEST:   begin d.op = OP_EXTEST;   d.sel = DR_BOUNDARY; d.test = 1'b1; end
        C_HIGHZ:    begin d.op = OP_HIGHZ;    d.hiz = 1'b1; end
        C_CLAMP:    begin d.op = OP_CLAMP;    d.test = 1'b1; end
        C_RUNT:     begin d.op = OP_RUNT;     d.test = 1'b1; end
        C_BREAD:    begin d.op = OP_BREAD;    d.sel = DR_BOUNDARY; end
        C_SELFTEST: begin d.op = OP_SELFTEST; d.sel = DR_BOUNDARY; end
        C_TOGGLE:   begin d.op = OP_TOGGLE;   d.test = 1'b1; end
        C_BCRSCAN:  begin d.op = OP_BCRSCAN;  d.sel = DR_CONTROL; end
        C_BYPASS:   d.op = OP_BYPASS;
        default:    d.op = OP_BYPASS;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic [IR_W-1:0] shift_q,
  output logic [IR_W-1:0] active_q,
  output instr_t          instr_q
);

  // capture and shift on the rising edge that leaves the state
  always_ff @(posedge tck) begin
    if (state == ST_CAP_IR)      shift_q <= IR_CAPTURE;
    else if (state == ST_SHF_IR) shift_q <= {tdi, shift_q[IR_W-1:1]};
  end

  // shadow copy and its decode change on the falling edge
  always_ff @(negedge tck) begin
    if (state == ST_RESET) begin
      active_q <= IR_RESET;
      instr_q  <= decode(IR_RESET);
    end else if (state == ST_UPD_IR) begin
      active_q <= shift_q;
      instr_q  <= decode(shift_q);
    end
  end

endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_port_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0002_702F
) (
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            bypass_q,
  output logic [ID_W-1:0] id_q
);

  always_ff @(posedge tck) begin
    if (state == ST_CAP_DR) begin
      bypass_q <= 1'b0;
      id_q     <= ID_VALUE;
    end else if (state == ST_SHF_DR) begin
      bypass_q <= tdi;
      id_q     <= {tdi, id_q[ID_W-1:1]};
    end
  end

endmodule

// File: rtl/scan_tdo.sv
module scan_tdo
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  tap_state_t state,
  input  dr_sel_t    sel,
  input  logic       ir_bit,
  input  logic       bypass_bit,
  input  logic       id_bit,
  input  logic       ext_bit,
  output logic       tdo,
  output logic       tdo_oe
);

  logic dr_bit;

  always_comb begin
    case (sel)
      DR_BYPASS: dr_bit = bypass_bit;
      DR_IDENT:  dr_bit = id_bit;
      default:   dr_bit = ext_bit;
    endcase
  end

  always_ff @(negedge tck) begin
    tdo_oe <= (state == ST_SHF_DR) || (state == ST_SHF_IR);
    if (state == ST_SHF_IR)      tdo <= ir_bit;
    else if (state == ST_SHF_DR) tdo <= dr_bit;
    else                         tdo <= 1'b0;
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0002_702F
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  input  logic       tdi,
  input  logic       ext_so,
  output logic       tdo,
  output logic       tdo_oe,
  output logic [3:0] op_code,
  output logic [1:0] dr_sel,
  output logic       test_mode,
  output logic       pins_hiz,
  output logic       run_active,
  output logic       dr_capture,
  output logic       dr_shift,
  output logic       dr_update
);

  tap_state_t      state;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  instr_t          instr;
  logic            bypass_q;
  logic [ID_W-1:0] id_shift;
  logic            ext_selected;

  scan_fsm i_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  scan_ir i_ir (
    .tck      (tck),
    .tdi      (tdi),
    .state    (state),
    .shift_q  (ir_shift),
    .active_q (ir_active),
    .instr_q  (instr)
  );

  scan_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_dr (
    .tck      (tck),
    .tdi      (tdi),
    .state    (state),
    .bypass_q (bypass_q),
    .id_q     (id_shift)
  );

  scan_tdo i_tdo (
    .tck        (tck),
    .state      (state),
    .sel        (instr.sel),
    .ir_bit     (ir_shift[0]),
    .bypass_bit (bypass_q),
    .id_bit     (id_shift[0]),
    .ext_bit    (ext_so),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe)
  );

  assign ext_selected = (instr.sel == DR_BOUNDARY) || (instr.sel == DR_CONTROL);

  assign op_code    = instr.op;
  assign dr_sel     = instr.sel;
  assign test_mode  = instr.test;
  assign pins_hiz   = instr.hiz;
  assign run_active = (state == ST_IDLE) &&
                      ((instr.op == OP_RUNT) || (instr.op == OP_TOGGLE));
  assign dr_capture = ext_selected && (state == ST_CAP_DR);
  assign dr_shift   = ext_selected && (state == ST_SHF_DR);
  assign dr_update  = ext_selected && (state == ST_UPD_DR);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0002_702F
) (
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_shift,
  input logic [IR_W-1:0] ir_active,
  input logic            bypass_q,
  input logic [ID_W-1:0] id_shift,
  input logic [3:0]      op_code,
  input logic            tdo_oe,
  input logic            dr_capture,
  input logic            dr_shift,
  input logic            dr_update
);

  AST_TMS_HOME: assert property (@(posedge tck) disable iff (rst)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == ST_RESET)); // R2

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_shift == IR_CAPTURE)); // R3

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> ((state == ST_SHF_DR) || (state == ST_SHF_IR))); // R4

  AST_OP_CHANGE_WHEN: assert property (@(posedge tck) disable iff (rst)
    (op_code != $past(op_code)) |-> ((state == ST_UPD_IR) || (state == ST_RESET))); // R6

  AST_PARITY_BYPASS: assert property (@(posedge tck) disable iff (rst)
    (^ir_active) |-> (op_code == 4'd0)); // R7

  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR) |=> (bypass_q == 1'b0)); // R10

  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR) |=> (id_shift == ID_VALUE)); // R11

  AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (rst)
    $onehot0({dr_capture, dr_shift, dr_update})); // R12

endmodule

bind scan_port_ctrl scan_port_chk #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_chk (
  .tck        (tck),
  .rst        (rst),
  .tms        (tms),
  .state      (state),
  .ir_shift   (ir_shift),
  .ir_active  (ir_active),
  .bypass_q   (bypass_q),
  .id_shift   (id_shift),
  .op_code    (op_code),
  .tdo_oe     (tdo_oe),
  .dr_capture (dr_capture),
  .dr_shift   (dr_shift),
  .dr_update  (dr_update)
);

// File: tb/test_scan_port_ctrl.sv
`timescale 1ns/1ps
module test_scan_port_ctrl;

  localparam logic [31:0] ID_EXP = 32'h0002_702F;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic ext_so = 1'b1;
  logic tdo, tdo_oe, test_mode, pins_hiz, run_active;
  logic dr_capture, dr_shift, dr_update;
  logic [3:0] op_code;
  logic [1:0] dr_sel;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] cur_op = 4'd1;

  typedef struct { logic b; string tag; } exp_item_t;
  exp_item_t exp_q[$];

  always #5 tck = ~tck;

  scan_port_ctrl i_scan_port_ctrl (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .ext_so(ext_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .op_code(op_code), .dr_sel(dr_sel),
    .test_mode(test_mode), .pins_hiz(pins_hiz), .run_active(run_active),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // set inputs mid-cycle, then let one rising edge consume them
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  // monitor: one queued bit per driven falling edge
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (tdo_oe === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk("R4", "unexpected tdo drive", 64'd1, 64'd0);
        end else begin
          exp_item_t e;
          e = exp_q.pop_front();
          chk(e.tag, "tdo bit", {63'd0, tdo}, {63'd0, e.b});
        end
      end
    end
  end

  task automatic dr_scan(input int n, input logic [63:0] din, input logic [63:0] dout,
                         input logic ext, input string tag);
    step(1'b1, 1'b0);                       // Select-DR
    step(1'b0, 1'b0);                       // Capture-DR
    chk("R12", "dr_capture", {63'd0, dr_capture}, {63'd0, ext});
    step(1'b0, 1'b0);                       // Shift-DR
    chk("R4", "oe before first fall", {63'd0, tdo_oe}, 64'd0);
    for (int i = 0; i < n; i++) exp_q.push_back('{dout[i], tag});
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    chk("R4", "oe held into Exit1", {63'd0, tdo_oe}, 64'd1);
    step(1'b1, 1'b0);                       // Update-DR
    chk("R4", "oe dropped", {63'd0, tdo_oe}, 64'd0);
    chk("R12", "dr_update", {63'd0, dr_update}, {63'd0, ext});
    step(1'b0, 1'b0);                       // Run-Test/Idle
  endtask

  // loads an instruction and leaves the controller in Update-IR, after the falling edge
  task automatic ir_scan(input logic [7:0] code);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);                       // Capture-IR
    step(1'b0, 1'b0);                       // Shift-IR
    for (int i = 0; i < 8; i++) exp_q.push_back('{IR_CHK[i], "R3"});
    for (int i = 0; i < 8; i++) step(i == 7, code[i]);
    step(1'b1, 1'b0);                       // Update-IR
    chk("R6", "old op kept before fall", {60'd0, op_code}, {60'd0, cur_op});
    @(negedge tck);
    #2;
  endtask

  localparam logic [7:0] IR_CHK = 8'b1000_0001;

  task automatic load(input logic [7:0] code, input logic [3:0] op, input logic [1:0] sel,
                      input logic tm, input logic hz, input string tag);
    ir_scan(code);
    chk(tag, "op_code", {60'd0, op_code}, {60'd0, op});
    chk(tag, "dr_sel", {62'd0, dr_sel}, {62'd0, sel});
    chk(tag, "test_mode", {63'd0, test_mode}, {63'd0, tm});
    chk(tag, "pins_hiz", {63'd0, pins_hiz}, {63'd0, hz});
    cur_op = op;
    step(1'b0, 1'b0);                       // Run-Test/Idle
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    rst = 1'b0;
    @(negedge tck);
    #2;
    chk("R1", "op_code", {60'd0, op_code}, 64'd1);
    chk("R1", "dr_sel", {62'd0, dr_sel}, 64'd1);
    chk("R1", "test_mode", {63'd0, test_mode}, 64'd0);
    chk("R1", "pins_hiz", {63'd0, pins_hiz}, 64'd0);
    chk("R1", "tdo_oe", {63'd0, tdo_oe}, 64'd0);
    chk("R1", "run_active", {63'd0, run_active}, 64'd0);
    step(1'b0, 1'b0);                       // Run-Test/Idle

    // R5: 40-bit scan through the identification register, tdi emerges 32 bits later
    dr_scan(40, 64'h0000_0000_0000_00A5, {24'd0, 8'hA5, ID_EXP}, 1'b0, "R5");
    // R11: fresh capture of the identity
    dr_scan(32, 64'hFFFF_FFFF, {32'd0, ID_EXP}, 1'b0, "R11");

    // R8 decode table and R10 bypass delay
    load(8'hFF, 4'd0, 2'd0, 1'b0, 1'b0, "R8");
    dr_scan(8, 64'hD6, {56'd0, 8'hD6 << 1}, 1'b0, "R10");
    load(8'h82, 4'd2, 2'd2, 1'b0, 1'b0, "R8");
    load(8'h02, 4'd0, 2'd0, 1'b0, 1'b0, "R7");   // odd parity
    load(8'h82, 4'd2, 2'd2, 1'b0, 1'b0, "R8");
    dr_scan(4, 64'h0, 64'hF, 1'b1, "R12");       // ext_so routed
    load(8'h0C, 4'd0, 2'd0, 1'b0, 1'b0, "R9");   // even parity, unknown code
    load(8'h00, 4'd3, 2'd2, 1'b1, 1'b0, "R8");
    load(8'h06, 4'd4, 2'd0, 1'b0, 1'b1, "R8");
    load(8'h87, 4'd5, 2'd0, 1'b1, 1'b0, "R8");
    load(8'h09, 4'd6, 2'd0, 1'b1, 1'b0, "R8");
    chk("R13", "run_active with run test", {63'd0, run_active}, 64'd1);
    load(8'h03, 4'd7, 2'd2, 1'b0, 1'b0, "R8");
    chk("R13", "run_active with boundary read", {63'd0, run_active}, 64'd0);
    load(8'h0A, 4'd8, 2'd2, 1'b0, 1'b0, "R8");
    load(8'h8B, 4'd9, 2'd0, 1'b1, 1'b0, "R8");
    chk("R13", "run_active with toggle", {63'd0, run_active}, 64'd1);
    load(8'h8E, 4'd10, 2'd3, 1'b0, 1'b0, "R8");
    dr_scan(3, 64'h0, 64'h7, 1'b1, "R12");
    load(8'h01, 4'd0, 2'd0, 1'b0, 1'b0, "R7");   // identity code with parity bit wrong
    load(8'h81, 4'd1, 2'd1, 1'b0, 1'b0, "R8");
    load(8'hFF, 4'd0, 2'd0, 1'b0, 1'b0, "R8");

    // R2: from Shift-DR, five high TMS edges reach Test-Logic-Reset
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);                       // Shift-DR
    exp_q.push_back('{1'b0, "R2"});
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    @(negedge tck);
    #2;
    chk("R2", "op_code after walk", {60'd0, op_code}, 64'd1);
    chk("R2", "dr_sel after walk", {62'd0, dr_sel}, 64'd1);
    chk("R4", "no bits left", 64'(exp_q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule